// File: doc/BRIEF.md
# Instruction Length Decoder

This block takes a window of raw instruction bytes for a 32-bit variable-length instruction set that has an optional 64-bit register extension. In a single pass it works out where the instruction ends and where each of its fields sits. Each field's offset depends on the field before it. The block therefore walks a chain of tests:

1. Leading prefix bytes.
2. An optional register-extension byte.
3. A one- or two-byte opcode.
4. An addressing byte, when the opcode calls for one.
5. A scaled-index byte, when the addressing byte calls for one.
6. A displacement.
7. An immediate.

Only a small fixed set of opcodes is recognised. Anything outside that set is reported as invalid.

A fetch stage presents up to 15 bytes, with byte 0 in bits [7:0], and raises `in_valid`. One clock later the block returns a result: the instruction length, the offset and size of every field, flags for the addressing byte and the index byte, the 64-bit operand-size bit, and an invalid flag. A steering stage uses these values to split the byte stream into instructions and to hand each field to later decode.

Top module: `ild_len_decoder`

## Requirements
- R1: Results appear one clock after the input. `out_valid` equals the previous cycle's `in_valid`. While `out_valid` is low, every length, offset, size and flag output is zero.
- R2: Leading bytes from the set 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2, 0xF3 are counted as legacy prefixes, up to four of them. A fifth legacy prefix in position 4 makes the instruction invalid.
- R3: A byte 0x40–0x4F that directly follows the legacy prefixes is an extension prefix. It is counted in `out_pfx_cnt`, and its bit 3 is reported on `out_rex_w`. The byte after it is always taken as the opcode, so a legacy prefix placed after it is rejected as an unknown opcode.
- R4: An opcode byte of 0x0F escapes to a two-byte opcode (`out_opc_sz` = 2). Of the second bytes, 0xAF and 0xB6 take an addressing byte and 0x0B takes none. Every other second byte is invalid.
- R5: The one-byte opcodes are handled as follows:
  - 0x01, 0x03, 0x89, 0x8B and 0xD8–0xDF take an addressing byte.
  - 0xC7 takes an addressing byte and an immediate.
  - 0x90 stands alone.
  - Every other opcode is invalid.
- R6: The addressing byte's bits [7:6] (mod) set the displacement size: 01 gives 1 byte, 10 gives 4 bytes, and 11 (register form) or 00 give none, except for the cases in R8.
- R7: The addressing byte is followed by an index byte when mod is not 11 and bits [2:0] (r/m) equal 4. It has no index byte in any other case.
- R8: A 4-byte displacement is present in two further cases: mod 00 with r/m 5, and mod 00 with an index byte whose bits [2:0] (base) equal 5.
- R9: The immediate of 0xC7 is 4 bytes. It is 2 bytes when a 0x66 prefix is present and the extension W bit is clear.
- R10: Field offsets form a running sum:
  - The opcode starts at the prefix count.
  - The addressing byte follows the opcode.
  - The index byte follows the addressing byte when present.
  - The displacement comes next, then the immediate.
  - `out_len` is the immediate offset plus the immediate size.
- R11: A computed length above 15 is invalid. An invalid instruction reports `out_invalid` = 1 and zero on every length, offset, size and flag output.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window holds bytes to decode |
| in_bytes | input | 120 | Byte window, byte 0 in bits [7:0] |
| out_valid | output | 1 | Result is present |
| out_invalid | output | 1 | Unknown opcode, too many prefixes or overlong |
| out_len | output | 5 | Total instruction length in bytes |
| out_pfx_cnt | output | 5 | Prefix bytes, including the extension byte |
| out_rex_w | output | 1 | 64-bit operand-size bit from the extension byte |
| out_opc_off | output | 5 | Offset of the first opcode byte |
| out_opc_sz | output | 2 | Opcode bytes (1 or 2) |
| out_has_modrm | output | 1 | Addressing byte present |
| out_modrm_off | output | 5 | Offset of the addressing byte |
| out_has_sib | output | 1 | Index byte present |
| out_sib_off | output | 5 | Offset of the index byte |
| out_disp_off | output | 5 | Offset of the displacement |
| out_disp_sz | output | 3 | Displacement bytes (0, 1 or 4) |
| out_imm_off | output | 5 | Offset of the immediate |
| out_imm_sz | output | 3 | Immediate bytes (0, 2 or 4) |

## Verification
The bench goes after the exceptions in the addressing byte: r/m 4 in the register form, r/m 5 with mod 00, and an index byte whose base is 5. A design that mixed up any of these would be off by one or four bytes, and every later instruction would be split wrongly. It also probes the edges of the prefix field, where an off-by-one miscounts or accepts a fifth legacy prefix, or takes a legacy byte after the extension prefix as a prefix rather than as the opcode. Further cases check that 0x66 shrinks the 0xC7 immediate only while W is clear, and that a length of exactly 15 is accepted while 16 is rejected with all fields cleared.

// File: rtl/ild_pkg.sv
package ild_pkg;

   typedef enum logic [0:0] {
      IMM_NONE = 1'b0,
      IMM_OPSZ = 1'b1
   } imm_kind_e;

   typedef struct packed {
      logic      known;
      logic      two_byte;
      logic      needs_modrm;
      imm_kind_e imm;
   } opc_info_t;

   localparam logic [7:0] OPSZ_PFX   = 8'h66;
   localparam logic [7:0] ESCAPE_OPC = 8'h0F;

   function automatic logic is_legacy_pfx(input logic [7:0] b);
      case (b)
         8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
         8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
         default:                          return 1'b0;
      endcase
   endfunction

   function automatic logic is_ext_pfx(input logic [7:0] b);
      return b[7:4] == 4'h4;
   endfunction

endpackage

// File: rtl/ild_pfx_scan.sv
module ild_pfx_scan
   import ild_pkg::*;
#(
   parameter int WIN_BYTES  = 15,
   parameter int MAX_LEGACY = 4,
   parameter int LEN_W      = 5
) (
   input  logic [WIN_BYTES*8-1:0] window,
   output logic [LEN_W-1:0]       pfx_cnt,
   output logic                   too_many,
   output logic                   ext_w,
   output logic                   opsz_seen
);
   localparam int SLOTS = MAX_LEGACY + 1;

   logic [SLOTS-1:0] leg;
   logic [SLOTS-1:0] run;
   logic [SLOTS-1:0] is66;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [7:0] b;
      assign b       = window[i*8 +: 8];
      assign leg[i]  = is_legacy_pfx(b);
      assign is66[i] = (b == OPSZ_PFX);
      if (i == 0) begin : g_head
         assign run[i] = leg[i];
      end else begin : g_tail
         assign run[i] = run[i-1] & leg[i];
      end
   end

   logic [LEN_W-1:0] leg_cnt;
   logic [7:0]       ext_b;
   logic             ext_hit;
   logic [2:0]       unused_ext_bits;

   assign too_many        = run[SLOTS-1];
   assign leg_cnt         = LEN_W'($countones(run[SLOTS-2:0]));
   assign ext_b           = window[int'(leg_cnt)*8 +: 8];
   assign ext_hit         = !too_many && is_ext_pfx(ext_b);
   assign ext_w           = ext_hit & ext_b[3];
   assign unused_ext_bits = ext_b[2:0];
   assign opsz_seen       = |(run[SLOTS-2:0] & is66[SLOTS-2:0]);
   assign pfx_cnt         = leg_cnt + LEN_W'(ext_hit);

endmodule

// File: rtl/ild_opc_class.sv
module ild_opc_class
   import ild_pkg::*;
(
   input  logic [7:0] op0,
   input  logic [7:0] op1,
   output opc_info_t  info
);
   always_comb begin
      info = '{known: 1'b0, two_byte: 1'b0, needs_modrm: 1'b0, imm: IMM_NONE};
      if (op0 == ESCAPE_OPC) begin
         info.two_byte = 1'b1;
         case (op1)
            8'hAF, 8'hB6: begin
               info.known       = 1'b1;
               info.needs_modrm = 1'b1;
            end
            8'h0B:   info.known = 1'b1;
            default: info.known = 1'b0;
         endcase
      end else if (op0[7:3] == 5'b11011) begin
         info.known       = 1'b1;
         info.needs_modrm = 1'b1;
      end else begin
         case (op0)
            8'h01, 8'h03, 8'h89, 8'h8B: begin
               info.known       = 1'b1;
               info.needs_modrm = 1'b1;
            end
            8'hC7: begin
               info.known       = 1'b1;
               info.needs_modrm = 1'b1;
               info.imm         = IMM_OPSZ;
            end
            8'h90:   info.known = 1'b1;
            default: info.known = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/ild_modrm_calc.sv
module ild_modrm_calc (
   input  logic       present,
   input  logic [7:0] modrm,
   input  logic [7:0] sib,
   output logic       has_sib,
   output logic [2:0] disp_sz
);
   logic [1:0] mode;
   logic [2:0] rm;
   logic [2:0] base;
   logic [7:0] unused_fields;

   assign mode          = modrm[7:6];
   assign rm            = modrm[2:0];
   assign base          = sib[2:0];
   assign unused_fields = {modrm[5:3], sib[7:3]};

   always_comb begin
      has_sib = present && (mode != 2'b11) && (rm == 3'd4);
      disp_sz = 3'd0;
      if (present) begin
         case (mode)
            2'b01: disp_sz = 3'd1;
            2'b10: disp_sz = 3'd4;
            2'b00: begin
               if (rm == 3'd5)                     disp_sz = 3'd4;
               else if (has_sib && base == 3'd5)   disp_sz = 3'd4;
            end
            default: disp_sz = 3'd0;
         endcase
      end
   end
endmodule

// File: rtl/ild_len_decoder.sv
module ild_len_decoder
   import ild_pkg::*;
#(
   parameter int WIN_BYTES  = 15,
   parameter int MAX_LEGACY = 4,
   parameter int MAX_LEN    = 15,
   parameter bit OPSZ_IMM16 = 1'b1,
   localparam int WORST     = MAX_LEGACY + 1 + 2 + 1 + 1 + 4 + 4,
   localparam int LEN_W     = $clog2(WORST + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [WIN_BYTES*8-1:0] in_bytes,
   output logic                   out_valid,
   output logic                   out_invalid,
   output logic [LEN_W-1:0]       out_len,
   output logic [LEN_W-1:0]       out_pfx_cnt,
   output logic                   out_rex_w,
   output logic [LEN_W-1:0]       out_opc_off,
   output logic [1:0]             out_opc_sz,
   output logic                   out_has_modrm,
   output logic [LEN_W-1:0]       out_modrm_off,
   output logic                   out_has_sib,
   output logic [LEN_W-1:0]       out_sib_off,
   output logic [LEN_W-1:0]       out_disp_off,
   output logic [2:0]             out_disp_sz,
   output logic [LEN_W-1:0]       out_imm_off,
   output logic [2:0]             out_imm_sz
);
   localparam logic [LEN_W-1:0] MAX_LEN_V = LEN_W'(MAX_LEN);

   if (MAX_LEGACY < 1) begin : g_bad_legacy
      $error("MAX_LEGACY must be at least 1");
   end
   if (WIN_BYTES < MAX_LEN) begin : g_bad_window
      $error("window narrower than the longest legal instruction");
   end
   if (WIN_BYTES < MAX_LEGACY + 5) begin : g_bad_reach
      $error("window cannot reach the index byte");
   end

   function automatic logic [7:0] fetch(input logic [LEN_W-1:0] idx);
      if (int'(idx) < WIN_BYTES) return in_bytes[int'(idx)*8 +: 8];
      return 8'h00;
   endfunction

   // prefix stage
   logic [LEN_W-1:0] pfx_cnt;
   logic             too_many;
   logic             ext_w;
   logic             opsz_seen;

   ild_pfx_scan #(
      .WIN_BYTES (WIN_BYTES),
      .MAX_LEGACY(MAX_LEGACY),
      .LEN_W     (LEN_W)
   ) u_pfx (
      .window   (in_bytes),
      .pfx_cnt  (pfx_cnt),
      .too_many (too_many),
      .ext_w    (ext_w),
      .opsz_seen(opsz_seen)
   );

   // opcode stage
   opc_info_t info;
   logic [7:0] op0, op1;
   assign op0 = fetch(pfx_cnt);
   assign op1 = fetch(pfx_cnt + LEN_W'(1));

   ild_opc_class u_opc (
      .op0 (op0),
      .op1 (op1),
      .info(info)
   );

   // addressing stage
   logic [1:0]       opc_sz;
   logic [LEN_W-1:0] modrm_off, sib_off, disp_off, imm_off, len;
   logic             has_sib;
   logic [2:0]       disp_sz, imm_sz;

   assign opc_sz    = info.two_byte ? 2'd2 : 2'd1;
   assign modrm_off = pfx_cnt + LEN_W'(opc_sz);

   ild_modrm_calc u_modrm (
      .present(info.needs_modrm),
      .modrm  (fetch(modrm_off)),
      .sib    (fetch(modrm_off + LEN_W'(1))),
      .has_sib(has_sib),
      .disp_sz(disp_sz)
   );

   // immediate sizing variant
   if (OPSZ_IMM16) begin : g_imm_opsz
      assign imm_sz = (info.imm == IMM_NONE) ? 3'd0 :
                      (opsz_seen && !ext_w)  ? 3'd2 : 3'd4;
   end else begin : g_imm_fixed
      logic unused_opsz;
      assign unused_opsz = opsz_seen;
      assign imm_sz      = (info.imm == IMM_NONE) ? 3'd0 : 3'd4;
   end

   assign sib_off  = modrm_off + LEN_W'(info.needs_modrm);
   assign disp_off = sib_off + LEN_W'(has_sib);
   assign imm_off  = disp_off + LEN_W'(disp_sz);
   assign len      = imm_off + LEN_W'(imm_sz);

   logic bad;
   assign bad = too_many || !info.known || (len > MAX_LEN_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_invalid   <= 1'b0;
         out_len       <= '0;
         out_pfx_cnt   <= '0;
         out_rex_w     <= 1'b0;
         out_opc_off   <= '0;
         out_opc_sz    <= '0;
         out_has_modrm <= 1'b0;
         out_modrm_off <= '0;
         out_has_sib   <= 1'b0;
         out_sib_off   <= '0;
         out_disp_off  <= '0;
         out_disp_sz   <= '0;
         out_imm_off   <= '0;
         out_imm_sz    <= '0;
      end else begin
         out_valid   <= in_valid;
         out_invalid <= in_valid && bad;
         if (in_valid && !bad) begin
            out_len       <= len;
            out_pfx_cnt   <= pfx_cnt;
            out_rex_w     <= ext_w;
            out_opc_off   <= pfx_cnt;
            out_opc_sz    <= opc_sz;
            out_has_modrm <= info.needs_modrm;
            out_modrm_off <= modrm_off;
            out_has_sib   <= has_sib;
            out_sib_off   <= sib_off;
            out_disp_off  <= disp_off;
            out_disp_sz   <= disp_sz;
            out_imm_off   <= imm_off;
            out_imm_sz    <= imm_sz;
         end else begin
            out_len       <= '0;
            out_pfx_cnt   <= '0;
            out_rex_w     <= 1'b0;
            out_opc_off   <= '0;
            out_opc_sz    <= '0;
            out_has_modrm <= 1'b0;
            out_modrm_off <= '0;
            out_has_sib   <= 1'b0;
            out_sib_off   <= '0;
            out_disp_off  <= '0;
            out_disp_sz   <= '0;
            out_imm_off   <= '0;
            out_imm_sz    <= '0;
         end
      end
   end
endmodule

// File: rtl/ild_len_decoder_chk.sv
module ild_len_decoder_chk #(
   parameter int MAX_LEGACY = 4,
   parameter int MAX_LEN    = 15,
   parameter int LEN_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic             out_invalid,
   input logic [LEN_W-1:0] out_len,
   input logic [LEN_W-1:0] out_pfx_cnt,
   input logic [LEN_W-1:0] out_opc_off,
   input logic             out_has_modrm,
   input logic             out_has_sib,
   input logic [2:0]       out_disp_sz,
   input logic [LEN_W-1:0] out_imm_off,
   input logic [2:0]       out_imm_sz
);
   localparam logic [LEN_W-1:0] MAX_LEN_V = LEN_W'(MAX_LEN);
   localparam logic [LEN_W-1:0] PFX_CAP_V = LEN_W'(MAX_LEGACY + 1);

   p_valid_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_len == '0 && !out_invalid && !out_has_modrm));

   p_pfx_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_pfx_cnt <= PFX_CAP_V);

   p_disp_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_disp_sz == 3'd0 || out_disp_sz == 3'd1 || out_disp_sz == 3'd4);

   p_sib_needs_modrm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_has_sib |-> out_has_modrm);

   p_imm_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_imm_sz == 3'd0 || out_imm_sz == 3'd2 || out_imm_sz == 3'd4);

   p_len_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid) |->
         (out_len == out_imm_off + LEN_W'(out_imm_sz) && out_opc_off == out_pfx_cnt));

   p_len_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_invalid) |-> (out_len >= LEN_W'(1) && out_len <= MAX_LEN_V));

   p_bad_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> (out_valid && out_len == '0 && !out_has_modrm && out_pfx_cnt == '0));
endmodule

bind ild_len_decoder ild_len_decoder_chk #(
   .MAX_LEGACY(MAX_LEGACY),
   .MAX_LEN   (MAX_LEN),
   .LEN_W     (LEN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .out_valid    (out_valid),
   .out_invalid  (out_invalid),
   .out_len      (out_len),
   .out_pfx_cnt  (out_pfx_cnt),
   .out_opc_off  (out_opc_off),
   .out_has_modrm(out_has_modrm),
   .out_has_sib  (out_has_sib),
   .out_disp_sz  (out_disp_sz),
   .out_imm_off  (out_imm_off),
   .out_imm_sz   (out_imm_sz)
);

// File: tb/sim_ild_len_decoder.sv
`timescale 1ns/1ps
module sim_ild_len_decoder;
   localparam int WB = 15;
   localparam int LW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [WB*8-1:0] in_bytes = '0;
   logic            out_valid, out_invalid, out_rex_w, out_has_modrm, out_has_sib;
   logic [LW-1:0]   out_len, out_pfx_cnt, out_opc_off, out_modrm_off, out_sib_off;
   logic [LW-1:0]   out_disp_off, out_imm_off;
   logic [1:0]      out_opc_sz;
   logic [2:0]      out_disp_sz, out_imm_sz;

   always #2 clk = ~clk;

   ild_len_decoder u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
      .out_valid(out_valid), .out_invalid(out_invalid), .out_len(out_len),
      .out_pfx_cnt(out_pfx_cnt), .out_rex_w(out_rex_w), .out_opc_off(out_opc_off),
      .out_opc_sz(out_opc_sz), .out_has_modrm(out_has_modrm),
      .out_modrm_off(out_modrm_off), .out_has_sib(out_has_sib),
      .out_sib_off(out_sib_off), .out_disp_off(out_disp_off),
      .out_disp_sz(out_disp_sz), .out_imm_off(out_imm_off), .out_imm_sz(out_imm_sz)
   );

   typedef struct {
      string tag;
      int    len, pfx, opc, hm, hs, dsz, isz, rexw, bad;
   } exp_t;

   exp_t       sbq[$];
   logic [7:0] bq[$];
   int         n_chk = 0;
   int         n_err = 0;
   bit         done  = 1'b0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: packs bq into the window and pushes the expected result
   task automatic send(input string tag, input int pfx, input int opc, input int hm,
                       input int hs, input int dsz, input int isz, input int rexw,
                       input int bad);
      exp_t e;
      e.tag = tag; e.bad = bad;
      if (bad != 0) begin
         e.len = 0; e.pfx = 0; e.opc = 0; e.hm = 0; e.hs = 0;
         e.dsz = 0; e.isz = 0; e.rexw = 0;
      end else begin
         e.len = bq.size(); e.pfx = pfx; e.opc = opc; e.hm = hm; e.hs = hs;
         e.dsz = dsz; e.isz = isz; e.rexw = rexw;
      end
      @(negedge clk);
      for (int i = 0; i < WB; i++)
         in_bytes[i*8 +: 8] = (i < bq.size()) ? bq[i] : 8'hCC;
      in_valid = 1'b1;
      sbq.push_back(e);
   endtask

   // monitor: compares each result against the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sbq.size() == 0) begin
            check("R1", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            int   disp_o, imm_o;
            e      = sbq.pop_front();
            disp_o = e.pfx + e.opc + e.hm + e.hs;
            imm_o  = disp_o + e.dsz;
            check(e.tag, "invalid", int'(out_invalid), e.bad);
            check(e.tag, "len",     int'(out_len),     e.len);
            check(e.tag, "pfx",     int'(out_pfx_cnt), e.pfx);
            check(e.tag, "rex_w",   int'(out_rex_w),   e.rexw);
            check(e.tag, "opc_sz",  int'(out_opc_sz),  e.opc);
            check(e.tag, "modrm",   int'(out_has_modrm), e.hm);
            check(e.tag, "sib",     int'(out_has_sib), e.hs);
            check(e.tag, "disp_sz", int'(out_disp_sz), e.dsz);
            check(e.tag, "imm_sz",  int'(out_imm_sz),  e.isz);
            if (e.bad == 0) begin
               check(e.tag, "R10 opc_off",   int'(out_opc_off),   e.pfx);
               check(e.tag, "R10 modrm_off", int'(out_modrm_off), e.pfx + e.opc);
               check(e.tag, "R10 sib_off",   int'(out_sib_off),   e.pfx + e.opc + e.hm);
               check(e.tag, "R10 disp_off",  int'(out_disp_off),  disp_o);
               check(e.tag, "R10 imm_off",   int'(out_imm_off),   imm_o);
            end
         end
      end
   end

   task automatic wrap_up();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         wrap_up();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", "valid", int'(out_valid), 0);
      check("R12", "len",   int'(out_len), 0);
      check("R12", "invalid", int'(out_invalid), 0);
      @(negedge clk) rst_n = 1'b1;

      // R5 single-byte and addressing opcodes
      bq = '{8'h90};                       send("R5 nop",      0,1,0,0,0,0,0,0);
      bq = '{8'h89, 8'hD8};                send("R6 regform",  0,1,1,0,0,0,0,0);
      bq = '{8'h8B, 8'h03};                send("R6 mod00",    0,1,1,0,0,0,0,0);
      bq = '{8'h8B, 8'h45, 8'h08};         send("R6 disp8",    0,1,1,0,1,0,0,0);
      bq = '{8'h03, 8'h85, 8'h10, 8'h20, 8'h30, 8'h40};
                                           send("R6 disp32",   0,1,1,0,4,0,0,0);
      bq = '{8'h01, 8'h05, 8'h34, 8'h12, 8'hFF, 8'h0C};
                                           send("R8 absolute", 0,1,1,0,4,0,0,0);
      bq = '{8'h8B, 8'h04, 8'h24};         send("R7 sib",      0,1,1,1,0,0,0,0);
      bq = '{8'h8B, 8'h04, 8'h25, 8'h01, 8'h02, 8'h03, 8'h04};
                                           send("R8 sib base5",0,1,1,1,4,0,0,0);
      bq = '{8'h8B, 8'h44, 8'h24, 8'h08};  send("R7 sib disp8",0,1,1,1,1,0,0,0);
      bq = '{8'h8B, 8'hC4};                send("R7 reg rm4",  0,1,1,0,0,0,0,0);
      bq = '{8'hC7, 8'h84, 8'hC3, 8'h08, 8'h00, 8'h00, 8'h00,
             8'h34, 8'h12, 8'h00, 8'h0F};  send("R9 c7 11B",   0,1,1,1,4,4,0,0);
      bq = '{8'h66, 8'hC7, 8'hC0, 8'h34, 8'h12};
                                           send("R9 imm16",    1,1,1,0,0,2,0,0);
      bq = '{8'h66, 8'h48, 8'hC7, 8'hC0, 8'h01, 8'h02, 8'h03, 8'h04};
                                           send("R9 R3 w wins",2,1,1,0,0,4,1,0);
      bq = '{8'h41, 8'h89, 8'hD8};         send("R3 ext w0",   1,1,1,0,0,0,0,0);
      bq = '{8'h48, 8'h66, 8'hC7, 8'hC0, 8'h01, 8'h02, 8'h03, 8'h04};
                                           send("R3 late pfx", 0,0,0,0,0,0,0,1);
      bq = '{8'h0F, 8'hAF, 8'hC1};         send("R4 2byte",    0,2,1,0,0,0,0,0);
      bq = '{8'h0F, 8'h0B};                send("R4 no modrm", 0,2,0,0,0,0,0,0);
      bq = '{8'h0F, 8'hB6, 8'h04, 8'h24};  send("R4 2byte sib",0,2,1,1,0,0,0,0);
      bq = '{8'h0F, 8'h05};                send("R4 unknown",  0,0,0,0,0,0,0,1);
      bq = '{8'hDC, 8'h45, 8'h08};         send("R5 fp",       0,1,1,0,1,0,0,0);
      bq = '{8'h62, 8'h00};                send("R5 unknown",  0,0,0,0,0,0,0,1);
      bq = '{8'hF3, 8'hF2, 8'h2E, 8'h67, 8'h90};
                                           send("R2 four",     4,1,0,0,0,0,0,0);
      bq = '{8'hF3, 8'hF2, 8'h2E, 8'h67, 8'h66, 8'h90};
                                           send("R2 fifth",    0,0,0,0,0,0,0,1);
      bq = '{8'h26, 8'h64, 8'h65, 8'h36, 8'hC7, 8'h84, 8'hC3, 8'h01, 8'h02,
             8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
                                           send("R11 len15",   4,1,1,1,4,4,0,0);
      bq = '{8'hF0, 8'h66, 8'h2E, 8'h3E, 8'h48, 8'hC7, 8'h84, 8'hC3, 8'h01,
             8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
                                           send("R11 len16",   0,0,0,0,0,0,0,1);

      @(negedge clk) in_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R1: idle output is cleared, every result consumed
      check("R1", "idle valid", int'(out_valid), 0);
      check("R1", "idle len",   int'(out_len), 0);
      check("R1", "pending",    sbq.size(), 0);
      done = 1'b1;
      wrap_up();
   end
endmodule